// File: doc/BRIEF.md
# Multiplexed Address/Data Burst Bus Slave Bridge

This block is a synchronous slave on a host bus whose lower address bits share wires with the data. The host runs a burst clock and frames each access with an active-low chip select. An active-low latch strobe marks the address phase. Active-low write and output enables give the direction. The 19-bit address is made of the 16-bit shared bus plus three dedicated upper lines. One 32-bit word moves per access, as two 16-bit beats with the low half first.

On the register side the bridge produces simple one-cycle strobes. A write strobe carries the assembled word and its address. A read strobe is issued as soon as the address is known. While the register side has not answered with a data-valid pulse, the bridge holds its active-low wait output low, and the host keeps clocking. Once the answer is latched, the bridge releases wait and puts the two halves on the shared bus in consecutive cycles. All logic runs on the burst clock. Raising chip select at any edge cancels whatever access is in progress.

Top module: `mbus_slave_bridge`

## Requirements
- R1: While reset is applied, and right after it, wait_no is 1, ad_oe_o is 0, and wr_stb_o and rd_stb_o are 0.
- R2: A rising edge with cs_ni=0 and adv_ni=0 in idle captures the address as {addr_hi_i, ad_i}, with addr_hi_i as bits 18..16 and ad_i as bits 15..0. This address appears on reg_addr_o and stays there through the access strobe.
- R3: If we_ni=0 at the address edge, the access is a write. The next edge takes data bits 15..0 from ad_i, and the edge after that takes bits 31..16. wr_stb_o is high for exactly one cycle after that second data edge, with the full word on wr_data_o.
- R4: If we_ni=1 at the address edge, the access is a read. rd_stb_o is high for exactly one cycle after the address edge, with the address on reg_addr_o.
- R5: On a read, wait_no is low from the address edge until the edge at which rd_valid_i is sampled high. That edge latches rd_data_i and raises wait_no. Read latency is unbounded.
- R6: After wait_no rises, ad_o carries read bits 15..0 for one cycle and then bits 31..16 for one cycle. The values are the ones latched at the valid edge, even if rd_data_i changes afterwards.
- R7: ad_oe_o is 1 only during those two read data cycles, and only while both cs_ni and oe_ni are 0. In every other cycle it is 0.
- R8: cs_ni=1 at any rising edge ends the access in progress. No strobe follows, wait_no goes high, the bus is released, and a later rd_valid_i pulse has no effect.
- R9: adv_ni=0 while cs_ni=1 starts no access: no strobe is issued and wait_no stays high.
- R10: A new access may begin on the edge directly after the last beat of the previous access, without chip select being raised in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Burst clock from the host |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| adv_ni | input | 1 | Address latch strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| ad_i | input | 16 | Shared address/data bus, host to slave |
| addr_hi_i | input | 3 | Upper address lines (bits 18..16) |
| ad_o | output | 16 | Shared bus value driven by the slave |
| ad_oe_o | output | 1 | Drive enable for ad_o onto the shared bus |
| wait_no | output | 1 | Wait, active low |
| reg_addr_o | output | 19 | Captured access address |
| wr_stb_o | output | 1 | One-cycle write strobe |
| wr_data_o | output | 32 | Assembled write word |
| rd_stb_o | output | 1 | One-cycle read request |
| rd_valid_i | input | 1 | Read data valid from the register side |
| rd_data_i | input | 32 | Read word from the register side |

## Verification
Writes use distinct upper-line values, all-ones and all-zero lower addresses, and unequal halves, so that swapped beats or a dropped upper address show up in the captured word. Reads use latencies of zero, three and seven cycles. These separate a wait that is timed by a counter from one that follows the valid pulse, and the register-side data is changed after the valid edge to prove it was latched. Access chains with no idle cycle between them exercise back-to-back starts. Cancels after each write beat and during a read wait, together with latch strobes issued while deselected, must produce no strobe and leave the slave idle.

// File: rtl/mbb_pkg.sv
package mbb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_LO,
    ST_WR_HI,
    ST_RD_WAIT,
    ST_RD_LO,
    ST_RD_HI
  } mbb_state_e;
endpackage

// File: rtl/mbb_addr_latch.sv
module mbb_addr_latch #(
  parameter int AD_W = 16,
  parameter int HI_W = 3,
  localparam int ADDR_W = AD_W + HI_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [AD_W-1:0]   ad_i,
  input  logic [HI_W-1:0]   hi_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    addr_o <= '0;
    else if (cap_i) addr_o <= {hi_i, ad_i};
  end
endmodule

// File: rtl/mbb_wr_assembler.sv
module mbb_wr_assembler #(
  parameter int AD_W = 16,
  parameter int NBEATS = 2,
  localparam int WORD_W = AD_W * NBEATS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NBEATS-1:0] beat_en_i,
  input  logic [AD_W-1:0]   ad_i,
  output logic [WORD_W-1:0] data_o,
  output logic              stb_o
);
  // one register slice per beat, low half first
  for (genvar g = 0; g < NBEATS; g++) begin : g_beat
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           data_o[g*AD_W +: AD_W] <= '0;
      else if (beat_en_i[g]) data_o[g*AD_W +: AD_W] <= ad_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stb_o <= 1'b0;
    else         stb_o <= beat_en_i[NBEATS-1];
  end

  AST_WR_STB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |=> !stb_o); // R3
endmodule

// File: rtl/mbb_rd_server.sv
module mbb_rd_server #(
  parameter int AD_W = 16,
  localparam int WORD_W = 2 * AD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              sel_hi_i,
  input  logic              drive_i,
  input  logic              cs_ni,
  input  logic              oe_ni,
  output logic [AD_W-1:0]   ad_o,
  output logic              ad_oe_o
);
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (load_i) word_q <= data_i;
  end

  assign ad_o    = sel_hi_i ? word_q[WORD_W-1:AD_W] : word_q[AD_W-1:0];
  assign ad_oe_o = drive_i & ~cs_ni & ~oe_ni;

  AST_OE_ONLY_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> (!cs_ni && !oe_ni)); // R7
endmodule

// File: rtl/mbus_slave_bridge.sv
module mbus_slave_bridge #(
  parameter int AD_W = 16,
  parameter int HI_W = 3,
  localparam int NBEATS = 2,
  localparam int ADDR_W = AD_W + HI_W,
  localparam int WORD_W = AD_W * NBEATS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              adv_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [AD_W-1:0]   ad_i,
  input  logic [HI_W-1:0]   addr_hi_i,
  output logic [AD_W-1:0]   ad_o,
  output logic              ad_oe_o,
  output logic              wait_no,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              wr_stb_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              rd_stb_o,
  input  logic              rd_valid_i,
  input  logic [WORD_W-1:0] rd_data_i
);
  import mbb_pkg::*;

  mbb_state_e state_q, state_d;
  logic              cap;
  logic [NBEATS-1:0] beat_en;
  logic              rd_load;

  assign cap = (state_q == ST_IDLE) && !cs_ni && !adv_ni;

  always_comb begin
    state_d = state_q;
    if (state_q == ST_IDLE) begin
      if (cap) state_d = we_ni ? ST_RD_WAIT : ST_WR_LO;
    end else if (cs_ni) begin
      state_d = ST_IDLE; // deselect cancels
    end else begin
      unique case (state_q)
        ST_WR_LO:   state_d = ST_WR_HI;
        ST_WR_HI:   state_d = ST_IDLE;
        ST_RD_WAIT: if (rd_valid_i) state_d = ST_RD_LO;
        ST_RD_LO:   state_d = ST_RD_HI;
        ST_RD_HI:   state_d = ST_IDLE;
        default:    state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_stb_o <= 1'b0;
    else         rd_stb_o <= cap && we_ni;
  end

  assign beat_en[0] = (state_q == ST_WR_LO) && !cs_ni;
  assign beat_en[1] = (state_q == ST_WR_HI) && !cs_ni;
  assign rd_load    = (state_q == ST_RD_WAIT) && !cs_ni && rd_valid_i;
  assign wait_no    = (state_q != ST_RD_WAIT);

  mbb_addr_latch #(.AD_W(AD_W), .HI_W(HI_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .ad_i   (ad_i),
    .hi_i   (addr_hi_i),
    .addr_o (reg_addr_o)
  );

  mbb_wr_assembler #(.AD_W(AD_W), .NBEATS(NBEATS)) u_wr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .beat_en_i (beat_en),
    .ad_i      (ad_i),
    .data_o    (wr_data_o),
    .stb_o     (wr_stb_o)
  );

  mbb_rd_server #(.AD_W(AD_W)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (rd_load),
    .data_i   (rd_data_i),
    .sel_hi_i (state_q == ST_RD_HI),
    .drive_i  ((state_q == ST_RD_LO) || (state_q == ST_RD_HI)),
    .cs_ni    (cs_ni),
    .oe_ni    (oe_ni),
    .ad_o     (ad_o),
    .ad_oe_o  (ad_oe_o)
  );

  AST_STB_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_stb_o && rd_stb_o)); // R3
  AST_RD_STB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stb_o |=> !rd_stb_o); // R4
  AST_RD_STB_WAITING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stb_o |-> !wait_no); // R5
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> $stable(reg_addr_o)); // R2
  AST_OE_NOT_WAITING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> wait_no); // R7
  AST_DESELECT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (wait_no && !ad_oe_o && !wr_stb_o && !rd_stb_o)); // R8
endmodule

// File: tb/sim_mbus_slave_bridge.sv
module sim_mbus_slave_bridge;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, adv_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [15:0] ad_in = '0;
  logic [2:0]  a_hi = '0;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_data = '0;
  logic [15:0] ad_out;
  logic        ad_oe, wait_n, wr_stb, rd_stb;
  logic [18:0] reg_addr;
  logic [31:0] wr_data;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    bit          is_wr;
    logic [18:0] addr;
    logic [31:0] data;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mbus_slave_bridge u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .adv_ni(adv_n), .we_ni(we_n),
    .oe_ni(oe_n), .ad_i(ad_in), .addr_hi_i(a_hi), .ad_o(ad_out),
    .ad_oe_o(ad_oe), .wait_no(wait_n), .reg_addr_o(reg_addr),
    .wr_stb_o(wr_stb), .wr_data_o(wr_data), .rd_stb_o(rd_stb),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per strobe
  always @(negedge clk) begin
    if (rst_n && (wr_stb || rd_stb)) begin
      if (q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R8/R9: actual unexpected strobe wr=%0b rd=%0b expected none", wr_stb, rd_stb);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(e.is_wr ? "R3 kind" : "R4 kind", {30'd0, wr_stb, rd_stb}, e.is_wr ? 32'd2 : 32'd1);
        chk("R2 addr", {13'd0, reg_addr}, {13'd0, e.addr});
        if (e.is_wr) chk("R3 data", wr_data, e.data);
      end
    end
  end

  task automatic idle(int n);
    cs_n = 1'b1; adv_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  // entered and left at a negedge; cs stays low on return
  task automatic bus_write(logic [18:0] addr, logic [31:0] data);
    q.push_back('{1'b1, addr, data});
    cs_n = 1'b0; adv_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    ad_in = addr[15:0]; a_hi = addr[18:16];
    @(negedge clk);
    adv_n = 1'b1; ad_in = data[15:0]; a_hi = 3'd0;
    @(negedge clk);
    ad_in = data[31:16];
    @(negedge clk);
    chk("R3 strobe", {31'd0, wr_stb}, 32'd1);
    we_n = 1'b1;
  endtask

  task automatic bus_read(logic [18:0] addr, int lat, logic [31:0] data);
    q.push_back('{1'b0, addr, 32'd0});
    cs_n = 1'b0; adv_n = 1'b0; we_n = 1'b1; oe_n = 1'b1;
    ad_in = addr[15:0]; a_hi = addr[18:16];
    @(negedge clk);
    chk("R5 wait low", {31'd0, wait_n}, 32'd0);
    adv_n = 1'b0; adv_n = 1'b1; oe_n = 1'b0; ad_in = '0; a_hi = 3'd0;
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk("R5 wait held", {31'd0, wait_n}, 32'd0);
      chk("R7 no drive in wait", {31'd0, ad_oe}, 32'd0);
    end
    rd_valid = 1'b1; rd_data = data;
    @(negedge clk);
    rd_valid = 1'b0;
    chk("R5 wait released", {31'd0, wait_n}, 32'd1);
    chk("R7 drive lo", {31'd0, ad_oe}, 32'd1);
    chk("R6 low half", {16'd0, ad_out}, {16'd0, data[15:0]});
    rd_data = ~data;
    @(negedge clk);
    chk("R7 drive hi", {31'd0, ad_oe}, 32'd1);
    chk("R6 high half", {16'd0, ad_out}, {16'd0, data[31:16]});
    @(negedge clk);
    chk("R7 released", {31'd0, ad_oe}, 32'd0);
    oe_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 wait", {31'd0, wait_n}, 32'd1);
    chk("R1 oe", {31'd0, ad_oe}, 32'd0);
    chk("R1 strobes", {30'd0, wr_stb, rd_stb}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {30'd0, wr_stb, rd_stb}, 32'd0);

    // R2 R3 writes
    bus_write(19'h5_1234, 32'hAA55_A5A5); idle(2);
    bus_write(19'h7_FFFF, 32'h1122_1212); idle(1);
    bus_write(19'h0_0000, 32'hFFFF_0000); idle(1);

    // R4 R5 R6 R7 reads with several latencies
    bus_read(19'h2_00C4, 0, 32'hBB77_B7B7); idle(1);
    bus_read(19'h6_8001, 3, 32'h0123_4567); idle(1);
    bus_read(19'h1_7FFE, 7, 32'hDEAD_BEEF); idle(1);

    // R10 back-to-back accesses with cs held low
    bus_write(19'h3_0010, 32'hCAFE_F00D);
    bus_read(19'h3_0014, 1, 32'h5A5A_0F0F);
    bus_write(19'h4_0018, 32'h8000_0001);
    idle(1);

    // R8 cancel after the low beat
    cs_n = 1'b0; adv_n = 1'b0; we_n = 1'b0; ad_in = 16'h0AAA; a_hi = 3'd2;
    @(negedge clk); adv_n = 1'b1; ad_in = 16'h1111;
    @(negedge clk); cs_n = 1'b1; ad_in = 16'h2222;
    @(negedge clk); chk("R8 no write strobe", {31'd0, wr_stb}, 32'd0);
    @(negedge clk); chk("R8 no write strobe later", {31'd0, wr_stb}, 32'd0);
    idle(1);
    // R8 cancel on the high beat edge
    cs_n = 1'b0; adv_n = 1'b0; we_n = 1'b0; ad_in = 16'h0BBB; a_hi = 3'd1;
    @(negedge clk); adv_n = 1'b1; ad_in = 16'h3333;
    @(negedge clk); cs_n = 1'b1; ad_in = 16'h4444;
    @(negedge clk); chk("R8 no strobe at hi edge", {31'd0, wr_stb}, 32'd0);
    idle(1);

    // R8 cancel during read wait; a late valid is ignored
    q.push_back('{1'b0, 19'h5_0555, 32'd0});
    cs_n = 1'b0; adv_n = 1'b0; we_n = 1'b1; ad_in = 16'h0555; a_hi = 3'd5;
    @(negedge clk); adv_n = 1'b1; oe_n = 1'b0;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
    chk("R8 wait high after cancel", {31'd0, wait_n}, 32'd1);
    rd_valid = 1'b1; rd_data = 32'h7777_7777;
    @(negedge clk); rd_valid = 1'b0; cs_n = 1'b0; adv_n = 1'b1;
    @(negedge clk);
    chk("R8 late valid ignored oe", {31'd0, ad_oe}, 32'd0);
    chk("R8 late valid ignored wait", {31'd0, wait_n}, 32'd1);
    idle(1);

    // R9 latch strobe while deselected
    cs_n = 1'b1; adv_n = 1'b0; we_n = 1'b1; ad_in = 16'h0FFF; a_hi = 3'd3;
    @(negedge clk); @(negedge clk);
    chk("R9 wait stays high", {31'd0, wait_n}, 32'd1);
    chk("R9 no strobe", {30'd0, wr_stb, rd_stb}, 32'd0);
    idle(1);
    bus_write(19'h6_0ABC, 32'h0F0F_F0F0); idle(2);

    chk("R3 R4 all strobes seen", q.size(), 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule